// File: doc/BRIEF.md
# In-Order Coalescing Store Buffer

This block sits between the store port of a core and a two-level cache model. Each accepted store carries a 64-byte-line address, a full line of data and a per-byte enable mask. The block keeps the stores in a small ring of line-sized entries and writes them to the cache one at a time from the oldest entry. A write counts as visible when the cache accepts it as a hit. Because only the oldest entry is ever offered to the cache, stores become visible in the order they were accepted.

A store to the same line as the youngest entry is folded into that entry instead of taking a new slot. The exception is a youngest entry that is currently being offered to the cache in state ISSUE. When the cache reports a miss on the oldest entry, that entry stays in place and the block waits for a fill-done pulse. It then offers the entry again, and this time the line is present. While such a miss is outstanding, a store that the core flags as a first-level hit is refused, and the core is held off until the whole buffer has drained. The core is held off only for this rule or because the buffer is full.

The issue controller has three states. IDLE means the buffer is empty and nothing is offered. ISSUE means the oldest entry is offered on the cache request port. WAIT_FILL means the oldest entry missed and the block is waiting for the fill. The transitions are as follows. IDLE goes to ISSUE when a store takes a new slot. ISSUE goes to WAIT_FILL when an accepted request misses. ISSUE goes to IDLE when an accepted hit retires the last entry and no new slot is taken in the same cycle. WAIT_FILL goes to ISSUE on fill-done. In every other case the state holds.

Top module: `ordered_store_buf`

## Requirements
- R1: After a synchronous active-high reset the buffer is empty, the block is in IDLE, `c_req_valid` is 0 and `st_ready` is 1.
- R2: Writes become visible, meaning a handshake with `c_req_ready`=1 and `c_req_miss`=0, strictly in the order the stores were accepted, at most one per cycle.
- R3: The buffer holds 8 line entries. When all 8 are in use, `st_ready` is 0 for a store that would need a new slot, and 1 for a store that can be merged.
- R4: A store whose line equals the youngest entry's line is merged into that entry. The entry's enable mask becomes the OR of the two masks, and each byte i whose new enable bit i is 1 takes byte i (bits 8i+7..8i) of the new data. No slot is used. This does not apply when the youngest entry is the only entry and the block is in ISSUE.
- R5: A store to the line of an older entry that is not the youngest takes a new slot and is written separately.
- R6: While the buffer is non-empty and not in WAIT_FILL, the oldest entry is offered with `c_req_valid`=1. Its line, data and mask stay stable until `c_req_ready` is 1.
- R7: A handshake with `c_req_miss`=1 keeps the entry at the head and drops `c_req_valid` until a `fill_done` pulse. The entry is then offered again.
- R8: While in WAIT_FILL, a valid store with `st_l1_hit`=1 sees `st_ready`=0 in that cycle, and `st_ready` stays 0 until the buffer is empty. The store therefore enters only after every older entry is visible.
- R9: A store accepted in the same cycle as a retire updates the occupancy correctly. A back-to-back stream of distinct lines against an always-hitting cache is accepted every cycle, and afterwards the buffer is empty.
- R10: During WAIT_FILL, stores with `st_l1_hit`=0 are accepted without stall while space or merging allows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Core presents a store |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| st_line | input | 34 | Line address of the store |
| st_data | input | 512 | Store data, one line |
| st_be | input | 64 | Byte enables |
| st_l1_hit | input | 1 | Lookup says the line is in the first-level cache |
| c_req_valid | output | 1 | Head entry offered to the cache |
| c_req_ready | input | 1 | Cache accepts the offered entry |
| c_req_miss | input | 1 | Accepted entry missed (valid with the handshake) |
| c_req_line | output | 34 | Line address of the head entry |
| c_req_data | output | 512 | Data of the head entry |
| c_req_be | output | 64 | Byte enables of the head entry |
| fill_done | input | 1 | One-cycle pulse: missing line has been filled |

## Verification
A wrong pointer or count inside the ring shows up as a wrong line, wrong bytes or a missing or extra item at the cache port. The scoreboard catches it at the first write handshake after the fault. A controller that leaves WAIT_FILL too early produces a commit while the fill is pending, and this is flagged in that same cycle. A missing drain hold lets a first-level-hit store into the buffer while older entries are still queued, which the bench detects at the moment the store is accepted. Merge faults appear as a wrong item count or wrong byte contents when the merged entry is written.

// File: rtl/osb_pkg.sv
package osb_pkg;
    typedef enum logic [1:0] {
        S_IDLE      = 2'd0,
        S_ISSUE     = 2'd1,
        S_WAIT_FILL = 2'd2
    } osb_state_e;
endpackage

// File: rtl/osb_line_ring.sv
module osb_line_ring #(
    parameter int ENTRIES    = 8,
    parameter int LINE_AW    = 34,
    parameter int LINE_BYTES = 64
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      push_new,
    input  logic                      push_merge,
    input  logic                      pop,
    input  logic [LINE_AW-1:0]        in_line,
    input  logic [LINE_BYTES*8-1:0]   in_data,
    input  logic [LINE_BYTES-1:0]     in_be,
    output logic [LINE_AW-1:0]        head_line,
    output logic [LINE_BYTES*8-1:0]   head_data,
    output logic [LINE_BYTES-1:0]     head_be,
    output logic [LINE_AW-1:0]        tail_line,
    output logic                      empty,
    output logic                      full,
    output logic                      single
);
    localparam int DW    = LINE_BYTES * 8;
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int CNT_W = $clog2(ENTRIES + 1);

    logic [LINE_AW-1:0] line_q [ENTRIES];
    logic [DW-1:0]      data_q [ENTRIES];
    logic [LINE_BYTES-1:0] be_q [ENTRIES];

    logic [PTR_W-1:0] rd_ptr, wr_ptr, tail_ptr;
    logic [CNT_W-1:0] count;
    logic [DW-1:0]    merged_data;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(ENTRIES - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign tail_ptr  = (wr_ptr == '0) ? PTR_W'(ENTRIES - 1) : wr_ptr - PTR_W'(1);
    assign empty     = (count == '0);
    assign full      = (count == CNT_W'(ENTRIES));
    assign single    = (count == CNT_W'(1));
    assign head_line = line_q[rd_ptr];
    assign head_data = data_q[rd_ptr];
    assign head_be   = be_q[rd_ptr];
    assign tail_line = line_q[tail_ptr];

    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
        assign merged_data[b*8 +: 8] = in_be[b] ? in_data[b*8 +: 8]
                                                : data_q[tail_ptr][b*8 +: 8];
    end

    always_ff @(posedge clk) begin
        if (push_new) begin
            line_q[wr_ptr] <= in_line;
            data_q[wr_ptr] <= in_data;
            be_q[wr_ptr]   <= in_be;
        end else if (push_merge) begin
            data_q[tail_ptr] <= merged_data;
            be_q[tail_ptr]   <= be_q[tail_ptr] | in_be;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_new) wr_ptr <= ptr_inc(wr_ptr);
            if (pop)      rd_ptr <= ptr_inc(rd_ptr);
            count <= count + CNT_W'(push_new) - CNT_W'(pop);
        end
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        !(push_new && full));
    p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(ENTRIES));
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
    p_merge_xor_new_r4: assert property (@(posedge clk) disable iff (rst)
        !(push_new && push_merge));
endmodule

// File: rtl/osb_order_ctl.sv
module osb_order_ctl #(
    parameter int LINE_AW = 34
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               st_valid,
    input  logic               st_l1_hit,
    input  logic [LINE_AW-1:0] st_line,
    output logic               st_ready,
    input  logic [LINE_AW-1:0] tail_line,
    input  logic               empty,
    input  logic               full,
    input  logic               single,
    input  logic               c_req_ready,
    input  logic               c_req_miss,
    input  logic               fill_done,
    output logic               c_req_valid,
    output logic               push_new,
    output logic               push_merge,
    output logic               pop
);
    import osb_pkg::*;

    osb_state_e state_q, state_d;
    logic hold_q;
    logic miss_wait, can_merge, hold_now, blocked, accept, fire;

    always_comb begin
        c_req_valid = 1'b0;
        miss_wait   = 1'b0;
        unique case (state_q)
            S_IDLE:      ;
            S_ISSUE:     c_req_valid = 1'b1;
            S_WAIT_FILL: miss_wait   = 1'b1;
            default:     ;
        endcase
    end

    assign can_merge  = !empty && (st_line == tail_line) && (!single || miss_wait);
    assign hold_now   = st_valid && st_l1_hit && miss_wait;
    assign blocked    = hold_now || (hold_q && !empty);
    assign st_ready   = !blocked && (can_merge || !full);
    assign accept     = st_valid && st_ready;
    assign push_merge = accept && can_merge;
    assign push_new   = accept && !can_merge;
    assign fire       = c_req_valid && c_req_ready;
    assign pop        = fire && !c_req_miss;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (push_new) state_d = S_ISSUE;
            S_ISSUE: begin
                if (fire && c_req_miss)             state_d = S_WAIT_FILL;
                else if (pop && single && !push_new) state_d = S_IDLE;
            end
            S_WAIT_FILL: if (fill_done) state_d = S_ISSUE;
            default:     state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            hold_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (hold_now)   hold_q <= 1'b1;
            else if (empty) hold_q <= 1'b0;
        end
    end

    p_idle_empty_r1: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_IDLE) == empty);
    p_req_held_r6: assert property (@(posedge clk) disable iff (rst)
        (c_req_valid && !c_req_ready) |=> c_req_valid);
    p_wait_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (fire && c_req_miss) |=> !c_req_valid);
    p_drain_block_r8: assert property (@(posedge clk) disable iff (rst)
        (st_valid && st_l1_hit && miss_wait) |=> (!st_ready || empty));
endmodule

// File: rtl/ordered_store_buf.sv
module ordered_store_buf #(
    parameter int ENTRIES    = 8,
    parameter int LINE_AW    = 34,
    parameter int LINE_BYTES = 64
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    st_valid,
    output logic                    st_ready,
    input  logic [LINE_AW-1:0]      st_line,
    input  logic [LINE_BYTES*8-1:0] st_data,
    input  logic [LINE_BYTES-1:0]   st_be,
    input  logic                    st_l1_hit,
    output logic                    c_req_valid,
    input  logic                    c_req_ready,
    input  logic                    c_req_miss,
    output logic [LINE_AW-1:0]      c_req_line,
    output logic [LINE_BYTES*8-1:0] c_req_data,
    output logic [LINE_BYTES-1:0]   c_req_be,
    input  logic                    fill_done
);
    logic push_new, push_merge, pop, empty, full, single;
    logic [LINE_AW-1:0] tail_line;

    osb_line_ring #(
        .ENTRIES(ENTRIES), .LINE_AW(LINE_AW), .LINE_BYTES(LINE_BYTES)
    ) u_ring (
        .clk(clk), .rst(rst),
        .push_new(push_new), .push_merge(push_merge), .pop(pop),
        .in_line(st_line), .in_data(st_data), .in_be(st_be),
        .head_line(c_req_line), .head_data(c_req_data), .head_be(c_req_be),
        .tail_line(tail_line),
        .empty(empty), .full(full), .single(single)
    );

    osb_order_ctl #(.LINE_AW(LINE_AW)) u_ctl (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_l1_hit(st_l1_hit), .st_line(st_line),
        .st_ready(st_ready),
        .tail_line(tail_line), .empty(empty), .full(full), .single(single),
        .c_req_ready(c_req_ready), .c_req_miss(c_req_miss), .fill_done(fill_done),
        .c_req_valid(c_req_valid),
        .push_new(push_new), .push_merge(push_merge), .pop(pop)
    );

    p_req_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (c_req_valid && !c_req_ready) |=>
            ($stable(c_req_line) && $stable(c_req_data) && $stable(c_req_be)));
endmodule

// File: tb/sim_ordered_store_buf.sv
module sim_ordered_store_buf;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 34;
    localparam int DW = 512;
    localparam int BW = 64;

    typedef struct packed {
        logic [AW-1:0] line;
        logic [DW-1:0] data;
        logic [BW-1:0] be;
    } item_t;

    logic clk = 1'b0, rst = 1'b1;
    logic st_valid = 1'b0, st_l1_hit = 1'b0, c_req_ready = 1'b0;
    logic [AW-1:0] st_line = '0;
    logic [DW-1:0] st_data = '0;
    logic [BW-1:0] st_be = '0;
    logic st_ready, c_req_valid, c_req_miss;
    logic [AW-1:0] c_req_line;
    logic [DW-1:0] c_req_data;
    logic [BW-1:0] c_req_be;
    logic fill_done = 1'b0, fill_pend = 1'b0, miss_cleared = 1'b0;
    logic [AW-1:0] miss_line = '1;
    int   fill_cnt = 0;

    item_t exp_q[$];
    int checks = 0, errs = 0, commits = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ordered_store_buf u0 (
        .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
        .st_line(st_line), .st_data(st_data), .st_be(st_be), .st_l1_hit(st_l1_hit),
        .c_req_valid(c_req_valid), .c_req_ready(c_req_ready), .c_req_miss(c_req_miss),
        .c_req_line(c_req_line), .c_req_data(c_req_data), .c_req_be(c_req_be),
        .fill_done(fill_done)
    );

    assign c_req_miss = (c_req_line == miss_line) && !miss_cleared;

    // cache fill model
    always @(posedge clk) begin
        if (rst) begin
            fill_done <= 1'b0; fill_pend <= 1'b0; miss_cleared <= 1'b0; fill_cnt <= 0;
        end else begin
            if (c_req_valid && c_req_ready && c_req_miss) begin
                fill_pend <= 1'b1; fill_cnt <= 6;
            end else if (fill_cnt > 1) fill_cnt <= fill_cnt - 1;
            else if (fill_cnt == 1) begin
                fill_cnt <= 0; fill_done <= 1'b1;
            end
            if (fill_done) begin
                fill_done <= 1'b0; fill_pend <= 1'b0; miss_cleared <= 1'b1;
            end
        end
    end

    task automatic chk(input bit ok, input string msg);
        checks++;
        if (!ok) begin errs++; $display("FAIL %s", msg); end
    endtask

    function automatic logic [DW-1:0] masked(input logic [DW-1:0] d, input logic [BW-1:0] be);
        logic [DW-1:0] r;
        for (int b = 0; b < BW; b++) r[b*8 +: 8] = be[b] ? d[b*8 +: 8] : 8'h00;
        return r;
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_d,
                                            input logic [DW-1:0] new_d,
                                            input logic [BW-1:0] be);
        logic [DW-1:0] r;
        for (int b = 0; b < BW; b++) r[b*8 +: 8] = be[b] ? new_d[b*8 +: 8] : old_d[b*8 +: 8];
        return r;
    endfunction

    // monitor: compare each visible write against the scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (fill_pend)
                chk(!c_req_valid, $sformatf("R7 request during pending fill: act valid=%0b exp 0", c_req_valid));
            if (c_req_valid && c_req_ready && !c_req_miss) begin
                commits++;
                if (exp_q.size() == 0)
                    chk(1'b0, $sformatf("R2 unexpected write: act line=%0h exp none", c_req_line));
                else begin
                    item_t e;
                    e = exp_q.pop_front();
                    chk(c_req_line == e.line,
                        $sformatf("R2 order: act line=%0h exp %0h", c_req_line, e.line));
                    chk(c_req_be == e.be && masked(c_req_data, c_req_be) == masked(e.data, e.be),
                        $sformatf("R4 contents line %0h: act be=%0h exp %0h", e.line, c_req_be, e.be));
                end
            end
        end
    end

    // driver: present a store, wait for acceptance; returns stalled cycles
    task automatic push(input logic [AW-1:0] line, input logic [DW-1:0] data,
                        input logic [BW-1:0] be, input bit hit, output int waited);
        bit rdy;
        st_valid = 1'b1; st_line = line; st_data = data; st_be = be; st_l1_hit = hit;
        waited = 0;
        do begin
            @(negedge clk); rdy = st_ready;
            if (!rdy) waited++;
            @(posedge clk); #1;
        end while (!rdy);
        st_valid = 1'b0; st_l1_hit = 1'b0;
    endtask

    task automatic expect_item(input logic [AW-1:0] line, input logic [DW-1:0] data,
                               input logic [BW-1:0] be);
        item_t e;
        e.line = line; e.data = data; e.be = be;
        exp_q.push_back(e);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) begin @(posedge clk); #1; end
        repeat (2) begin @(posedge clk); #1; end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(st_ready === 1'b1, $sformatf("R1 reset st_ready: act %0b exp 1", st_ready));
        chk(c_req_valid === 1'b0, $sformatf("R1 reset c_req_valid: act %0b exp 0", c_req_valid));
        @(posedge clk); #1;
    end

    initial begin
        int w, c0;
        logic [DW-1:0] dA, dB, dB2, dA2, d;
        @(negedge rst); @(posedge clk); @(posedge clk); #1;

        // R4/R5/R6: cache stalled, merge into youngest only
        dA = {16{32'hA1A1_0001}}; dB = {16{32'hB2B2_0002}};
        dB2 = {16{32'hC3C3_0003}}; dA2 = {16{32'hD4D4_0004}};
        c_req_ready = 1'b0; c0 = commits;
        push(34'h10, dA, '1, 1'b0, w);             expect_item(34'h10, dA, '1);
        push(34'h20, dB, {32'h0, 32'hFFFF_FFFF}, 1'b0, w);
        push(34'h20, dB2, {16'hFFFF, 48'h1}, 1'b0, w);
        expect_item(34'h20, merge(dB, dB2, {16'hFFFF, 48'h1}), {16'hFFFF, 16'h0, 32'hFFFF_FFFF});
        push(34'h10, dA2, 64'hF, 1'b0, w);        expect_item(34'h10, dA2, 64'hF);
        @(negedge clk);
        chk(c_req_valid === 1'b1 && c_req_line == 34'h10,
            $sformatf("R6 head offered while stalled: act line=%0h exp 10", c_req_line));
        @(posedge clk); #1;
        c_req_ready = 1'b1;
        drain();
        chk(commits - c0 == 3, $sformatf("R5 separate write for older line: act %0d exp 3", commits - c0));

        // R3: full buffer
        c_req_ready = 1'b0; c0 = commits;
        for (int i = 0; i < 8; i++) begin
            d = {16{32'(i) ^ 32'h5A5A_0000}};
            push(34'h100 + AW'(i), d, '1, 1'b0, w);
            if (i != 7) expect_item(34'h100 + AW'(i), d, '1);
        end
        st_valid = 1'b1; st_line = 34'h200; st_be = '1;
        @(negedge clk);
        chk(st_ready === 1'b0, $sformatf("R3 full, new line: act ready=%0b exp 0", st_ready));
        @(posedge clk); #1;
        push(34'h107, {16{32'hEEEE_EEEE}}, 64'h3, 1'b0, w);
        chk(w == 0, $sformatf("R3 full, merge accepted: act waited=%0d exp 0", w));
        expect_item(34'h107, merge({16{32'(7) ^ 32'h5A5A_0000}}, {16{32'hEEEE_EEEE}}, 64'h3), '1);
        c_req_ready = 1'b1;
        drain();
        chk(commits - c0 == 8, $sformatf("R3 entries written: act %0d exp 8", commits - c0));

        // R7/R8/R10: miss, merge in wait, hit store held until drained
        miss_line = 34'h300;
        push(34'h300, {16{32'h1111_1111}}, '1, 1'b0, w);
        @(posedge clk); #1;
        push(34'h300, {16{32'h2222_2222}}, 64'hFF, 1'b0, w);
        chk(w == 0, $sformatf("R10 merge during miss: act waited=%0d exp 0", w));
        expect_item(34'h300, merge({16{32'h1111_1111}}, {16{32'h2222_2222}}, 64'hFF), '1);
        push(34'h310, {16{32'h3333_3333}}, '1, 1'b0, w);
        chk(w == 0, $sformatf("R10 miss-line store accepted: act waited=%0d exp 0", w));
        expect_item(34'h310, {16{32'h3333_3333}}, '1);
        push(34'h400, {16{32'h4444_4444}}, '1, 1'b1, w);
        chk(w >= 3, $sformatf("R8 hit store stalled: act waited=%0d exp >=3", w));
        chk(exp_q.size() == 0, $sformatf("R8 older writes visible first: act pending=%0d exp 0", exp_q.size()));
        expect_item(34'h400, {16{32'h4444_4444}}, '1);
        drain();

        // R9: back-to-back stream with retire every cycle
        c0 = commits;
        for (int i = 0; i < 12; i++) begin
            d = {16{32'(i) + 32'h7700_0000}};
            push(34'h500 + AW'(i), d, '1, 1'b0, w);
            expect_item(34'h500 + AW'(i), d, '1);
            chk(w == 0, $sformatf("R9 stream store %0d: act waited=%0d exp 0", i, w));
        end
        drain();
        chk(commits - c0 == 12, $sformatf("R9 writes: act %0d exp 12", commits - c0));
        @(negedge clk);
        chk(c_req_valid === 1'b0 && st_ready === 1'b1,
            $sformatf("R9 empty after stream: act valid=%0b ready=%0b exp 0 1", c_req_valid, st_ready));
        chk(exp_q.size() == 0, $sformatf("R2 leftover items: act %0d exp 0", exp_q.size()));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errs++;
            $display("FAIL watchdog: act hung exp finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
            $finish;
        end
    end
endmodule